// File: doc/BRIEF.md
# DRAM request packet decoder

This block sits between a memory device's 12-line request bus and its command logic. A request packet arrives as two 12-bit halves on consecutive clock edges. A framing input marks the first half. The block joins the halves into a 24-bit word and reads a 4-bit operation field to pick the packet format:

- row activate,
- column read/write,
- masked column write,
- precharge/refresh,
- extended.

It extracts the fields of the chosen format and emits one-cycle command strobes with their bank, row, column, mask, refresh and extended-opcode qualifiers.

Some commands carry an encoded issue delay:

- activate: 0 or 1 cycle,
- read/write: 0 or 1 cycle,
- precharge: 0 to 3 cycles.

The block holds each delayed command in a short per-type pipeline and emits it exactly that many cycles late. A precharge/refresh packet can issue a precharge and a refresh together. The block reports two error cases as one-cycle flags:

- an opcode that is not assigned,
- two commands of the same type that fall due in the same cycle.

Top module: `rqpkt_decoder`

## Requirements
- R1: A synchronous active-high reset clears the half-packet phase and every pending delayed command, so no strobe or error flag is high in the cycle after reset, and a command still waiting at reset is never emitted.
- R2: A cycle with `req_valid` high captures word bits 23..12 from `req_bus`, and the next cycle captures bits 11..0; the `req_valid` value in that second cycle is ignored. An undelayed command's strobe is high for exactly the one cycle after the second-half edge.
- R3: Opcode `word[23:20]`=0001 is an activate. The fields are bank=`word[18:16]`, row=`word[15:4]` and sub-row=`word[3:2]`; the block pulses `act_pulse` with them on `act_bank`, `act_row` and `act_subrow`.
- R4: In an activate, `word[19]`=1 delays `act_pulse` by exactly one cycle; 0 issues it undelayed.
- R5: Opcode 0010 is a column access. The fields are delay=`word[19]` (adds one cycle), select=`word[18]` (0 read, 1 write), bank=`word[17:15]`, column=`word[14:9]` and sub-column=`word[8:5]`. The block pulses `col_rd` or `col_wr`, and `col_mask` reads 0.
- R6: `word[23:22]`=11 is a masked write, issued undelayed. The fields are bank=`word[21:19]`, column=`word[18:13]`, sub-column=`word[12:9]` and mask=`word[8:1]`; the block pulses `col_wrm` with `col_mask`.
- R7: Opcode 0011 is precharge/refresh. When `word[19]`=1 it pulses `pre_pulse` with `pre_bank`=`word[16:14]`, delayed by `word[18:17]` cycles (0 to 3). When `word[19]`=0 it issues no precharge.
- R8: In a precharge/refresh packet, a nonzero refresh code `word[13:11]` pulses `ref_pulse` undelayed, with `ref_op`=`word[13:11]` and `ref_addr`=`word[10:3]`. The refresh is independent of the precharge, so both can fire in the same cycle.
- R9: A precharge/refresh packet with `word[19]`=0 and `word[13:11]`=0 asserts no strobe at all, whatever its other bits hold.
- R10: Opcode 0100 is extended. A nonzero `word[19:16]` pulses `ext_pulse` with `ext_op`; the value 0 issues nothing.
- R11: Opcode 0000 issues nothing and flags nothing. Opcodes 0101 through 1011 issue no strobe and pulse `err_opcode` for one cycle, in the cycle an undelayed command would appear.
- R12: When a new command of a type falls due in the same cycle as a pending one of that type, the older pending command is kept and the new one is dropped. `err_collide` pulses in the cycle an undelayed command of the new packet would appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Marks the first half of a packet |
| req_bus | input | 12 | Request half-packet |
| act_pulse | output | 1 | Activate strobe |
| act_bank | output | 3 | Activate bank |
| act_row | output | 12 | Activate row |
| act_subrow | output | 2 | Activate sub-row |
| col_rd | output | 1 | Column read strobe |
| col_wr | output | 1 | Column write strobe |
| col_wrm | output | 1 | Masked write strobe |
| col_bank | output | 3 | Column bank |
| col_col | output | 6 | Column address |
| col_sub | output | 4 | Sub-column address |
| col_mask | output | 8 | Write mask (0 unless masked write) |
| pre_pulse | output | 1 | Precharge strobe |
| pre_bank | output | 3 | Precharge bank |
| ref_pulse | output | 1 | Refresh strobe |
| ref_op | output | 3 | Refresh sub-opcode |
| ref_addr | output | 8 | Refresh address field |
| ext_pulse | output | 1 | Extended command strobe |
| ext_op | output | 4 | Extended sub-opcode |
| err_opcode | output | 1 | Unassigned opcode flag |
| err_collide | output | 1 | Same-type command collision flag |

## Verification
The block has no parameters: the field layout and the delay depths are fixed by the packet format, so the bench builds it as it stands. At that size every precharge delay from 0 to 3 is reachable. Back-to-back packets bring two precharge collisions within reach: a delay-3 command followed by a delay-1 command, and a delay-2 command followed by an undelayed one. The bench also covers a reset that arrives while a delayed command is still pending.

// File: rtl/rqpkt_decoder.sv
module rqpkt_decoder (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [11:0] req_bus,
  output logic        act_pulse,
  output logic [2:0]  act_bank,
  output logic [11:0] act_row,
  output logic [1:0]  act_subrow,
  output logic        col_rd,
  output logic        col_wr,
  output logic        col_wrm,
  output logic [2:0]  col_bank,
  output logic [5:0]  col_col,
  output logic [3:0]  col_sub,
  output logic [7:0]  col_mask,
  output logic        pre_pulse,
  output logic [2:0]  pre_bank,
  output logic        ref_pulse,
  output logic [2:0]  ref_op,
  output logic [7:0]  ref_addr,
  output logic        ext_pulse,
  output logic [3:0]  ext_op,
  output logic        err_opcode,
  output logic        err_collide
);

  localparam logic [3:0] OP_NOP  = 4'h0;
  localparam logic [3:0] OP_ACT  = 4'h1;
  localparam logic [3:0] OP_COL  = 4'h2;
  localparam logic [3:0] OP_ROWP = 4'h3;
  localparam logic [3:0] OP_EXT  = 4'h4;
  localparam int PRE_DEPTH = 4;
  localparam int ACT_W = 17;
  localparam int COL_W = 23;

  logic        phase;
  logic [11:0] hi_q;
  logic [23:0] word;
  logic [3:0]  op;

  assign word = {hi_q, req_bus};
  assign op   = word[23:20];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
    end else if (!phase && req_valid) begin
      phase <= 1'b1;
      hi_q  <= req_bus;
    end else begin
      phase <= 1'b0;
    end
  end

  logic is_colm, is_act, is_col, is_rowp, is_ext, is_bad;
  assign is_colm = phase && (op[3:2] == 2'b11);
  assign is_act  = phase && (op == OP_ACT);
  assign is_col  = phase && (op == OP_COL);
  assign is_rowp = phase && (op == OP_ROWP);
  assign is_ext  = phase && (op == OP_EXT);
  assign is_bad  = phase && !is_colm && (op > OP_EXT);

  // activate pipeline: position 0 drives the outputs
  logic [1:0]             av;
  logic [1:0][ACT_W-1:0]  ap;
  logic [1:0]             av_up, act_sel;
  logic [1:0][ACT_W-1:0]  ap_up;
  logic [ACT_W-1:0]       act_new;

  assign av_up   = {1'b0, av[1]};
  assign ap_up   = {{ACT_W{1'b0}}, ap[1]};
  assign act_sel = is_act ? (word[19] ? 2'b10 : 2'b01) : 2'b00;
  assign act_new = word[18:2];

  // column pipeline: payload = {kind, bank, col, sub, mask}
  logic [1:0]             cv;
  logic [1:0][COL_W-1:0]  cp;
  logic [1:0]             cv_up, col_sel;
  logic [1:0][COL_W-1:0]  cp_up;
  logic [COL_W-1:0]       col_new;

  assign cv_up   = {1'b0, cv[1]};
  assign cp_up   = {{COL_W{1'b0}}, cp[1]};
  assign col_sel = is_colm ? 2'b01 :
                   is_col  ? (word[19] ? 2'b10 : 2'b01) : 2'b00;
  assign col_new = is_colm ? {2'b11, word[21:19], word[18:13], word[12:9], word[8:1]}
                           : {(word[18] ? 2'b10 : 2'b01), word[17:15], word[14:9],
                              word[8:5], 8'h00};

  // precharge pipeline
  logic [PRE_DEPTH-1:0]       pv, pv_up, pre_sel;
  logic [PRE_DEPTH-1:0][2:0]  pb, pb_up;

  assign pv_up   = {1'b0, pv[PRE_DEPTH-1:1]};
  assign pb_up   = {3'b000, pb[PRE_DEPTH-1:1]};
  assign pre_sel = (is_rowp && word[19]) ? (PRE_DEPTH'(1) << word[18:17])
                                         : {PRE_DEPTH{1'b0}};

  logic collide;
  assign collide = |(av_up & act_sel) | |(cv_up & col_sel) | |(pv_up & pre_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      av <= '0;
      cv <= '0;
      pv <= '0;
    end else begin
      av <= av_up | act_sel;
      cv <= cv_up | col_sel;
      pv <= pv_up | pre_sel;
    end
    for (int i = 0; i < 2; i++) begin
      ap[i] <= av_up[i] ? ap_up[i] : act_new;
      cp[i] <= cv_up[i] ? cp_up[i] : col_new;
    end
    for (int i = 0; i < PRE_DEPTH; i++)
      pb[i] <= pv_up[i] ? pb_up[i] : word[16:14];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_pulse   <= 1'b0;
      ext_pulse   <= 1'b0;
      err_opcode  <= 1'b0;
      err_collide <= 1'b0;
    end else begin
      ref_pulse   <= is_rowp && (word[13:11] != 3'b000);
      ext_pulse   <= is_ext && (word[19:16] != 4'h0);
      err_opcode  <= is_bad;
      err_collide <= collide;
    end
    ref_op   <= word[13:11];
    ref_addr <= word[10:3];
    ext_op   <= word[19:16];
  end

  assign act_pulse  = av[0];
  assign act_bank   = ap[0][16:14];
  assign act_row    = ap[0][13:2];
  assign act_subrow = ap[0][1:0];

  assign col_rd   = cv[0] && (cp[0][22:21] == 2'b01);
  assign col_wr   = cv[0] && (cp[0][22:21] == 2'b10);
  assign col_wrm  = cv[0] && (cp[0][22:21] == 2'b11);
  assign col_bank = cp[0][20:18];
  assign col_col  = cp[0][17:12];
  assign col_sub  = cp[0][11:8];
  assign col_mask = cp[0][7:0];

  assign pre_pulse = pv[0];
  assign pre_bank  = pb[0];

  logic unused_ok;
  assign unused_ok = (op == OP_NOP);

endmodule

// File: rtl/rqpkt_decoder_chk.sv
module rqpkt_decoder_chk (
  input logic clk,
  input logic rst,
  input logic act_pulse,
  input logic col_rd,
  input logic col_wr,
  input logic col_wrm,
  input logic pre_pulse,
  input logic ref_pulse,
  input logic ext_pulse,
  input logic err_opcode,
  input logic err_collide
);

  // R5 R6: a column slot carries one command kind
  a_r5_col_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({col_rd, col_wr, col_wrm}));

  // R11: a bad opcode comes with no refresh or extended strobe
  a_r11_bad_silent: assert property (@(posedge clk) disable iff (rst)
    err_opcode |-> (!ref_pulse && !ext_pulse));

  // R11: the opcode flag lasts one cycle
  a_r11_err_single: assert property (@(posedge clk) disable iff (rst)
    err_opcode |=> !err_opcode);

  // R8: refresh strobes are single-cycle
  a_r8_ref_single: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse);

  // R10: extended strobes are single-cycle
  a_r10_ext_single: assert property (@(posedge clk) disable iff (rst)
    ext_pulse |=> !ext_pulse);

  // R12: the collision flag lasts one cycle
  a_r12_collide_single: assert property (@(posedge clk) disable iff (rst)
    err_collide |=> !err_collide);

  // R1: nothing is issued in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(act_pulse || col_rd || col_wr || col_wrm || pre_pulse ||
                     ref_pulse || ext_pulse || err_opcode || err_collide));

endmodule

bind rqpkt_decoder rqpkt_decoder_chk i_chk (
  .clk(clk), .rst(rst), .act_pulse(act_pulse), .col_rd(col_rd), .col_wr(col_wr),
  .col_wrm(col_wrm), .pre_pulse(pre_pulse), .ref_pulse(ref_pulse),
  .ext_pulse(ext_pulse), .err_opcode(err_opcode), .err_collide(err_collide)
);

// File: tb/test_rqpkt_decoder.sv
module test_rqpkt_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [11:0] req_bus = '0;
  logic act_pulse, col_rd, col_wr, col_wrm, pre_pulse, ref_pulse, ext_pulse;
  logic err_opcode, err_collide;
  logic [2:0] act_bank, col_bank, pre_bank, ref_op;
  logic [11:0] act_row;
  logic [1:0] act_subrow;
  logic [5:0] col_col;
  logic [3:0] col_sub, ext_op;
  logic [7:0] col_mask, ref_addr;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rqpkt_decoder i_rqpkt_decoder (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] strobes();
    return {act_pulse, col_rd, col_wr, col_wrm, pre_pulse, ref_pulse, ext_pulse,
            err_opcode, err_collide};
  endfunction

  task automatic send(logic [23:0] w);
    @(negedge clk); req_valid = 1'b1; req_bus = w[23:12];
    @(negedge clk); req_valid = 1'b0; req_bus = w[11:0];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); req_valid = 1'b0; req_bus = '0;
    end
  endtask

  function automatic logic [23:0] mk_act(logic d, logic [2:0] b, logic [11:0] r, logic [1:0] s);
    return {4'h1, d, b, r, s, 2'b00};
  endfunction
  function automatic logic [23:0] mk_col(logic d, logic w, logic [2:0] b, logic [5:0] c, logic [3:0] s);
    return {4'h2, d, w, b, c, s, 5'b0};
  endfunction
  function automatic logic [23:0] mk_colm(logic [2:0] b, logic [5:0] c, logic [3:0] s, logic [7:0] m);
    return {2'b11, b, c, s, m, 1'b0};
  endfunction
  function automatic logic [23:0] mk_rowp(logic [2:0] p, logic [2:0] b, logic [2:0] r, logic [7:0] a);
    return {4'h3, p, b, r, a, 3'b0};
  endfunction

  task automatic t_reset();
    check("R1 strobes in reset", strobes(), 0);
    @(negedge clk); rst = 1'b0;
    check("R1 strobes after reset", strobes(), 0);
    send(mk_rowp(3'b111, 3'd4, 3'd0, 8'h0));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R1 pending dropped by reset", strobes(), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_act();
    send(mk_act(1'b0, 3'd5, 12'hA5C, 2'd2));
    @(negedge clk);
    check("R2 act undelayed", act_pulse, 1);
    check("R3 act fields", {act_bank, act_row, act_subrow}, {3'd5, 12'hA5C, 2'd2});
    @(negedge clk);
    check("R2 act one cycle", act_pulse, 0);
    send(mk_act(1'b1, 3'd2, 12'h3F1, 2'd1));
    @(negedge clk);
    check("R4 act delayed not early", act_pulse, 0);
    @(negedge clk);
    check("R4 act delayed", act_pulse, 1);
    check("R4 act delayed fields", {act_bank, act_row, act_subrow}, {3'd2, 12'h3F1, 2'd1});
    idle(3);
  endtask

  task automatic t_col();
    send(mk_col(1'b0, 1'b0, 3'd6, 6'h15, 4'hB));
    @(negedge clk);
    check("R5 read strobes", {col_rd, col_wr, col_wrm}, 3'b100);
    check("R5 read fields", {col_bank, col_col, col_sub, col_mask}, {3'd6, 6'h15, 4'hB, 8'h00});
    send(mk_col(1'b1, 1'b1, 3'd1, 6'h2E, 4'h4));
    @(negedge clk);
    check("R5 write delayed not early", {col_rd, col_wr, col_wrm}, 3'b000);
    @(negedge clk);
    check("R5 write delayed", {col_rd, col_wr, col_wrm}, 3'b010);
    check("R5 write fields", {col_bank, col_col, col_sub}, {3'd1, 6'h2E, 4'h4});
    send(mk_colm(3'd3, 6'h2A, 4'h9, 8'hC3));
    @(negedge clk);
    check("R6 masked write strobes", {col_rd, col_wr, col_wrm}, 3'b001);
    check("R6 masked write fields", {col_bank, col_col, col_sub, col_mask}, {3'd3, 6'h2A, 4'h9, 8'hC3});
    idle(3);
  endtask

  task automatic t_pre();
    for (int d = 0; d < 4; d++) begin
      send(mk_rowp({1'b1, 2'(d)}, 3'(d + 1), 3'd0, 8'h0));
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check($sformatf("R7 precharge delay %0d cycle %0d", d, k), pre_pulse, (k == d));
        if (k == d) check("R7 precharge bank", pre_bank, d + 1);
      end
    end
    send(mk_rowp(3'b100, 3'd6, 3'd5, 8'h9E));
    @(negedge clk);
    check("R8 both strobes", {pre_pulse, ref_pulse}, 2'b11);
    check("R8 refresh fields", {pre_bank, ref_op, ref_addr}, {3'd6, 3'd5, 8'h9E});
    send(mk_rowp(3'b011, 3'd7, 3'd0, 8'hFF));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R9 no-op packet silent", strobes(), 0);
    end
  endtask

  task automatic t_ext();
    send({4'h4, 4'h7, 16'hFFFF});
    @(negedge clk);
    check("R10 ext strobe", {ext_pulse, ext_op}, {1'b1, 4'h7});
    send({4'h4, 4'h0, 16'h0});
    @(negedge clk);
    check("R10 ext zero silent", strobes(), 0);
    send({4'h6, 20'hFFFFF});
    @(negedge clk);
    check("R11 bad opcode", strobes(), 9'b000000010);
    send({4'hB, 20'h12345});
    @(negedge clk);
    check("R11 bad opcode top", strobes(), 9'b000000010);
    send(24'h0ABCDE);
    @(negedge clk);
    check("R11 nop silent", strobes(), 0);
    idle(2);
  endtask

  task automatic t_collide();
    send(mk_rowp(3'b111, 3'd5, 3'd0, 8'h0));
    send(mk_rowp(3'b101, 3'd2, 3'd0, 8'h0));
    @(negedge clk);
    check("R12 collide flag", {err_collide, pre_pulse}, 2'b10);
    @(negedge clk);
    check("R12 older kept", {err_collide, pre_pulse, pre_bank}, {2'b01, 3'd5});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R12 newer dropped", pre_pulse, 0);
    end
    send(mk_rowp(3'b110, 3'd3, 3'd0, 8'h0));
    send(mk_rowp(3'b100, 3'd4, 3'd0, 8'h0));
    @(negedge clk);
    check("R12 collide undelayed", {err_collide, pre_pulse, pre_bank}, {2'b11, 3'd3});
    @(negedge clk);
    check("R12 undelayed dropped", {err_collide, pre_pulse}, 2'b00);
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_act();
    t_col();
    t_pre();
    t_ext();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule